// File: doc/BRIEF.md
# Retriggerable Power-Good Masking Timer

This block drives the power-good indication of a multiphase core regulator. A window comparator outside the block reports whether the output sits above or below a ±10% band around the present set point. The block turns those two flags into an active-high pull-down enable for an open-drain power-good pin, so a 1 on the output means power-good is low.

The regulation target moves whenever the six-bit voltage code or either sleep-state input changes. The output then needs time to slew to the new level. During that time the comparator flags are expected to be wrong, so any such change opens a blanking interval of `MASK_CYC` clock cycles. While the interval is open, the output keeps its last value. A further change inside an open interval starts the full count again. The output is also held asserted while the regulator is not running and until soft-start has reached its arming level. A low run input asserts the output at once, without waiting for a clock edge.

Top module: `pgood_mask_timer`

## Requirements
- R1: While reset is active and on the first cycle after it, `pg_pull_o` is 1.
- R2: When `run_i` is 0, `pg_pull_o` is 1 in the same cycle, with no clock edge needed, whatever the other inputs are.
- R3: When `run_i` is 1 and `ss_armed_i` is 0 at a clock edge, `pg_pull_o` is 1 after that edge. This takes priority over an open mask.
- R4: With run and armed both 1 and no mask open, `pg_pull_o` after an edge equals the OR of `ov_i` and `uv_i` sampled at that edge.
- R5: A change of `vid_i` relative to its value at the previous edge opens a mask. The mask covers the edge at which the change is seen and the next `MASK_CYC`-1 edges. On those edges `pg_pull_o` keeps its value, provided run and armed are 1.
- R6: A change of `deep_slp_i` or `deeper_slp_i` relative to the previous edge opens a mask exactly as in R5. The first edge after reset never counts as a change.
- R7: A change seen while a mask is open restarts the full `MASK_CYC`-edge interval from that edge.
- R8: An over-voltage flag and an under-voltage flag are both ignored while a mask is open.
- R9: If a flag is still 1 on the first edge after the mask closes, `pg_pull_o` becomes 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Regulator enabled |
| ss_armed_i | input | 1 | Soft-start has reached its arming level |
| ov_i | input | 1 | Output above the window |
| uv_i | input | 1 | Output below the window |
| vid_i | input | 6 | Voltage code |
| deep_slp_i | input | 1 | Deep-sleep offset request |
| deeper_slp_i | input | 1 | Deeper-sleep fixed level request |
| pg_pull_o | output | 1 | 1 = pull power-good low |

## Verification
A target change and a mask restart can coincide with a supply event: a drop of run or of the armed flag in the same cycle that the code changes, or a fresh code change on the exact edge where the previous mask would have closed. The bench drives these collisions on purpose and also drives a flag change on the cycle the mask expires. A behavioural model counts the remaining mask edges with a plain integer, and each cycle the output is compared against it. The immediate run override is also checked one nanosecond after run falls, before any clock edge arrives.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
    parameter int unsigned PGM_VID_W = 6;
    parameter int unsigned PGM_SLP_W = 2;

    typedef struct packed {
        logic [PGM_VID_W-1:0] vid;
        logic [PGM_SLP_W-1:0] slp;
        logic                 seen;
    } pgm_det_t;
endpackage

// File: rtl/pgm_change_det.sv
module pgm_change_det
    import pgm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PGM_VID_W-1:0] vid_i,
    input  logic [PGM_SLP_W-1:0] slp_i,
    output logic                 chg_o
);
    pgm_det_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.vid  = vid_i;
        st_d.slp  = slp_i;
        st_d.seen = 1'b1;
        chg_o     = st_q.seen && ((vid_i != st_q.vid) || (slp_i != st_q.slp));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: no change is reported before a first sample was taken
    assert_first_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.seen |-> !chg_o);
endmodule

// File: rtl/pgm_mask_cnt.sv
module pgm_mask_cnt #(
    parameter int unsigned MASK_CYC = 27500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,
    output logic active_o
);
    localparam int unsigned CNT_W = $clog2(MASK_CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(MASK_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (chg_i)               st_d.cnt = RELOAD;
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        active_o = chg_i || (st_q.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: any change re-arms the whole interval
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> st_q.cnt == RELOAD);
    // R5: the count never leaves its range
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(MASK_CYC));
endmodule

// File: rtl/pgood_mask_timer.sv
module pgood_mask_timer
    import pgm_pkg::*;
#(
    parameter int unsigned MASK_CYC = 27500
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic                 ss_armed_i,
    input  logic                 ov_i,
    input  logic                 uv_i,
    input  logic [PGM_VID_W-1:0] vid_i,
    input  logic                 deep_slp_i,
    input  logic                 deeper_slp_i,
    output logic                 pg_pull_o
);
    logic chg;
    logic mask_active;
    logic pull_d, pull_q;

    pgm_change_det u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .vid_i (vid_i),
        .slp_i ({deeper_slp_i, deep_slp_i}),
        .chg_o (chg)
    );

    pgm_mask_cnt #(.MASK_CYC(MASK_CYC)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .chg_i    (chg),
        .active_o (mask_active)
    );

    always_comb begin
        if (!run_i || !ss_armed_i) pull_d = 1'b1;
        else if (mask_active)      pull_d = pull_q;
        else                       pull_d = ov_i || uv_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pull_q <= 1'b1;
        else        pull_q <= pull_d;
    end

    assign pg_pull_o = pull_q || !run_i;

    // R2: dropping run pulls power-good low at once
    assert_run_pull_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> pg_pull_o);
    // R3: not armed forces the pull-down after the edge
    assert_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i || !ss_armed_i) |=> pull_q);
    // R4: outside the mask the flags go straight through
    assert_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && ss_armed_i && !mask_active) |=> pull_q == $past(ov_i || uv_i));
    // R8: inside the mask the output holds
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && ss_armed_i && mask_active) |=> $stable(pull_q));
    // R9: a fault still present when the mask closes is reported
    assert_expire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_active && $past(mask_active) && run_i && ss_armed_i && (ov_i || uv_i)) |=> pull_q);
endmodule

// File: tb/pgood_mask_timer_bench.sv
module pgood_mask_timer_bench;
    localparam int M = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_i = 1'b0, ss_armed_i = 1'b0, ov_i = 1'b0, uv_i = 1'b0;
    logic [5:0] vid_i = 6'd0;
    logic deep_slp_i = 1'b0, deeper_slp_i = 1'b0;
    logic pg_pull_o;

    int n_chk = 0, n_fail = 0;
    string tag = "R1";
    bit done = 0;

    // model state
    int   rem = 0;
    bit   seen = 0, mpull = 1;
    logic [5:0] pv = '0;
    logic [1:0] ps = '0;

    always #2 clk = ~clk;

    pgood_mask_timer #(.MASK_CYC(M)) u_pgood_mask_timer (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .ss_armed_i(ss_armed_i),
        .ov_i(ov_i), .uv_i(uv_i), .vid_i(vid_i), .deep_slp_i(deep_slp_i),
        .deeper_slp_i(deeper_slp_i), .pg_pull_o(pg_pull_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            seen = 0; rem = 0; mpull = 1;
        end else begin
            bit chg, act, np;
            chg = seen && ((vid_i != pv) || ({deeper_slp_i, deep_slp_i} != ps));
            act = chg || (rem > 0);
            if (!run_i || !ss_armed_i) np = 1;
            else if (act)              np = mpull;
            else                       np = ov_i || uv_i;
            rem = chg ? M - 1 : (rem > 0 ? rem - 1 : 0);
            seen = 1;
            mpull = np;
        end
        pv = vid_i;
        ps = {deeper_slp_i, deep_slp_i};
    end

    task automatic check(input logic exp, input string req);
        n_chk++;
        if (pg_pull_o !== exp) begin
            n_fail++;
            $display("FAIL %s: pg_pull_o=%b expected %b at %0t", req, pg_pull_o, exp, $time);
        end
    endtask

    always @(negedge clk) if (!done) check(rst_n ? (mpull | !run_i) : 1'b1, tag);

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog: done=0 expected 1");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1; tag = "R1";
        tick(2);
        tag = "R3"; run_i = 1; tick(4);
        tag = "R4"; ss_armed_i = 1; tick(2);
        ov_i = 1; tick(2); ov_i = 0; uv_i = 1; tick(2); uv_i = 0; tick(2);
        // R5 + R9: code change with a fault that outlives the mask
        tag = "R5"; vid_i = 6'd5; uv_i = 1; tick(M - 1);
        tag = "R9"; tick(3); uv_i = 0; tick(2);
        // R8: over-voltage pulse hidden by the mask
        tag = "R8"; vid_i = 6'd9; tick(2); ov_i = 1; tick(2); ov_i = 0; tick(M);
        // R6: sleep-state transitions
        tag = "R6"; deep_slp_i = 1; ov_i = 1; tick(M - 1); ov_i = 0; tick(3);
        deeper_slp_i = 1; uv_i = 1; tick(M + 2); uv_i = 0; tick(2);
        // R7: restart mid-mask and exactly at the last masked edge
        tag = "R7"; vid_i = 6'd20; uv_i = 1; tick(5); vid_i = 6'd21; tick(M - 1);
        vid_i = 6'd22; tick(M + 1); uv_i = 0; tick(2);
        // R2: immediate override, also colliding with a code change
        tag = "R2"; vid_i = 6'd30; tick(2); run_i = 0; #0;
        #1 check(1'b1, "R2");
        tick(3); run_i = 1; tick(M + 2);
        vid_i = 6'd31; run_i = 0; #1 check(1'b1, "R2"); tick(2); run_i = 1; tick(M + 2);
        // R3 priority over an open mask
        tag = "R3"; vid_i = 6'd40; ss_armed_i = 0; tick(3); ss_armed_i = 1; tick(M + 2);
        // R1: reset again mid-mask
        tag = "R1"; vid_i = 6'd41; tick(2); rst_n = 0; tick(2); rst_n = 1; tick(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule